// File: doc/BRIEF.md
# Four-Channel PWM Waveform Generator

This block produces four pulse-width-modulated outputs from one shared 15-bit counter. The counter advances on a prescaled tick. It runs in one of two ways: rising only and wrapping, which gives edge-aligned pulses, or rising to the top value and then falling back, which gives centre-aligned pulses. Each channel compares the counter against its own 15-bit compare value. Bit 15 of the sample word that loaded the channel sets the output polarity.

Compare values reach the block as 16-bit sample words over a valid/ready stream. A decoder gathers the words of one step into a staging buffer. The number of words per step is set by the load mode: one word shared by all channels, two words split by channel pair, four words with one per channel, or a waveform step. In a waveform step the fourth word replaces the counter top. While the generator runs, a staged step is applied only at a period boundary, and each boundary raises a one-cycle period-end pulse. While the generator is disabled, a staged step is applied at once.

A small register port with a write strobe, a 2-bit address and 16-bit data sets the enable, the counting style, the load mode, the prescaler code and the top value.

Top module: `quad_pwm_gen`

## Requirements
- R1: Address 1 bits 2:0 hold the prescaler code N. The counter advances once every 2^N clock cycles.
- R2: In rising-only mode, address 0 bit 1 is 0. The counter runs 0..T and wraps, so a period lasts (T+1)·2^N cycles. `periodEnd` is high for exactly one cycle, the first cycle of each period, when the counter reads 0.
- R3: In up-down mode, address 0 bit 1 is 1. The counter runs 0..T..1, so a period lasts 2T·2^N cycles for T>0. A channel with compare c, where 0<c<T, is active for (2c−1)·2^N cycles.
- R4: A write to address 2 sets the top to data bits 14:0. If data bit 15 is set, the top is clamped to 32767.
- R5: A channel is active while counter < compare, using the low 15 bits of its word. Word bit 15 set inverts the output level.
- R6: Compare 0 keeps the channel inactive for the whole period. A compare at or above the top keeps it active for the whole period.
- R7: Load mode 0 (address 0 bits 3:2 = 0) takes one word per step and applies it to all four channels.
- R8: Load mode 1 takes two words per step. The first drives channels 0 and 1, the second drives channels 2 and 3.
- R9: Load mode 2 takes four words per step, applied in the order channel 0, 1, 2, 3.
- R10: Load mode 3 takes four words per step. Words one to three drive channels 0 to 2. The low 15 bits of word four become the counter top, and channel 3 stays low.
- R11: After reset and while address 0 bit 0 (enable) is 0, all outputs are low. Disabling keeps the loaded compare values, which apply again on re-enable.
- R12: While enabled, a complete staged step takes effect only at the next period boundary. `smpReady` is low while a step waits, and is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 control, 1 prescaler, 2 top |
| cfgData | input | 16 | Configuration write data |
| smpValid | input | 1 | Sample word valid |
| smpWord | input | 16 | Sample word: bit 15 polarity, bits 14:0 value |
| smpReady | output | 1 | Block can accept a sample word |
| pwmOut | output | 4 | PWM outputs, channel 0 in bit 0 |
| periodEnd | output | 1 | One-cycle pulse at the start of each period |

## Verification
Each load mode receives words with distinct values per channel, so a wrong routing of a word to a channel shows up as a wrong active-cycle count. Compare values of zero, exactly the top, above the top and with the polarity bit set separate the edge rules from the ordinary compare rule. Measured period lengths under different prescaler codes, both counting styles, a clamped top and a waveform-supplied top separate the counter and divider paths. A step pushed mid-period, followed by a check of the output level at once and of the next whole period, shows whether values are held until the boundary. Disabling and re-enabling shows that compare values are retained.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int CH_N   = 4;
  localparam int CNT_W  = 15;
  localparam int WORD_W = 16;
  localparam int PRE_W  = 3;

  typedef enum logic [1:0] {
    LD_COMMON  = 2'd0,
    LD_GROUPED = 2'd1,
    LD_INDIV   = 2'd2,
    LD_WAVE    = 2'd3
  } loadMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;    // generator enabled
    logic load;   // apply a staged step now
    logic flush;  // discard partial / pending step
  } strobe_t;

  // which staged word feeds channel ch
  function automatic logic [1:0] srcWord(loadMode_e m, int ch);
    case (m)
      LD_COMMON:  return 2'd0;
      LD_GROUPED: return 2'(ch >> 1);
      default:    return 2'(ch);
    endcase
  endfunction
endpackage

// File: rtl/qpwm_ctrl.sv
module qpwm_ctrl
  import qpwm_pkg::*;
#(
  parameter int TOP_INIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  input  logic [CNT_W-1:0]  topAct,
  output strobe_t           strb,
  output logic [CNT_W-1:0]  cnt,
  output loadMode_e         loadMode,
  output logic [CNT_W-1:0]  topCfg,
  output logic              periodEnd
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             enable, upDown, dirUp, dirNxt, tick, boundary;
  logic [PRE_W-1:0] presc;
  logic [DIV_W-1:0] divCnt, divLim;
  logic [CNT_W-1:0] cntNxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      upDown   <= 1'b0;
      loadMode <= LD_COMMON;
      presc    <= '0;
      topCfg   <= CNT_W'(TOP_INIT);
    end else if (cfgWe) begin
      case (cfgAddr)
        2'd0: begin
          enable   <= cfgData[0];
          upDown   <= cfgData[1];
          loadMode <= loadMode_e'(cfgData[3:2]);
        end
        2'd1: presc <= cfgData[PRE_W-1:0];
        2'd2: topCfg <= (cfgData[WORD_W-1:CNT_W] != '0) ? '1 : cfgData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign divLim = (DIV_W'(1) << presc) - DIV_W'(1);
  assign tick   = enable && (divCnt >= divLim);

  always_comb begin
    cntNxt = cnt;
    dirNxt = dirUp;
    if (dirUp) begin
      if (cnt >= topAct) begin
        if (!upDown || topAct == '0) cntNxt = '0;
        else begin
          cntNxt = topAct - CNT_W'(1);
          dirNxt = 1'b0;
        end
      end else cntNxt = cnt + CNT_W'(1);
    end else if (cnt != '0) cntNxt = cnt - CNT_W'(1);
    if (cntNxt == '0) dirNxt = 1'b1;
  end

  assign boundary = tick && (cntNxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt    <= '0;
      cnt       <= '0;
      dirUp     <= 1'b1;
      periodEnd <= 1'b0;
    end else begin
      periodEnd <= boundary;
      if (!enable) begin
        divCnt <= '0;
        cnt    <= '0;
        dirUp  <= 1'b1;
      end else if (tick) begin
        divCnt <= '0;
        cnt    <= cntNxt;
        dirUp  <= dirNxt;
      end else divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign strb.run   = enable;
  assign strb.load  = boundary || !enable;
  assign strb.flush = cfgWe && (cfgAddr == 2'd0);
endmodule

// File: rtl/qpwm_datapath.sv
module qpwm_datapath
  import qpwm_pkg::*;
#(
  parameter int TOP_INIT = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strb,
  input  loadMode_e             loadMode,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      topCfg,
  input  logic                  smpValid,
  input  logic [WORD_W-1:0]     smpWord,
  output logic                  smpReady,
  output logic [CNT_W-1:0]      topAct,
  output logic [CH_N-1:0]       pwmOut,
  output logic [CH_N*CNT_W-1:0] cmpBus
);
  logic [WORD_W-1:0] stage [CH_N];
  logic [1:0]        wordIdx, lastIdx;
  logic              stageFull, accept, apply, isWave;

  assign isWave   = (loadMode == LD_WAVE);
  assign smpReady = !stageFull;
  assign accept   = smpValid && smpReady && !strb.flush;
  assign apply    = strb.load && stageFull && !strb.flush;

  always_comb begin
    case (loadMode)
      LD_COMMON:  lastIdx = 2'd0;
      LD_GROUPED: lastIdx = 2'd1;
      default:    lastIdx = 2'd3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordIdx   <= '0;
      stageFull <= 1'b0;
      for (int k = 0; k < CH_N; k++) stage[k] <= '0;
    end else if (strb.flush) begin
      wordIdx   <= '0;
      stageFull <= 1'b0;
    end else if (apply) begin
      stageFull <= 1'b0;
    end else if (accept) begin
      stage[wordIdx] <= smpWord;
      if (wordIdx == lastIdx) begin
        wordIdx   <= '0;
        stageFull <= 1'b1;
      end else wordIdx <= wordIdx + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) topAct <= CNT_W'(TOP_INIT);
    else if (strb.load && !strb.flush) begin
      if (isWave) begin
        if (stageFull) topAct <= stage[CH_N-1][CNT_W-1:0];
      end else topAct <= topCfg;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic [CNT_W-1:0]  cmp;
    logic              pol, active, driven;
    logic [WORD_W-1:0] src;

    assign src = stage[srcWord(loadMode, i)];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp <= '0;
        pol <= 1'b0;
      end else if (apply && !(isWave && i == CH_N - 1)) begin
        cmp <= src[CNT_W-1:0];
        pol <= src[WORD_W-1];
      end
    end

    assign active = (cmp != '0) && ((cnt < cmp) || (cmp >= topAct));
    assign driven = strb.run && !(isWave && i == CH_N - 1);
    assign pwmOut[i] = driven && (active ^ pol);
    assign cmpBus[i*CNT_W +: CNT_W] = cmp;
  end
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen
  import qpwm_pkg::*;
#(
  parameter int TOP_INIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [WORD_W-1:0] cfgData,
  input  logic              smpValid,
  input  logic [WORD_W-1:0] smpWord,
  output logic              smpReady,
  output logic [CH_N-1:0]   pwmOut,
  output logic              periodEnd
);
  strobe_t                strb;
  loadMode_e              loadMode;
  logic [CNT_W-1:0]       cnt, topCfg, topAct;
  logic [CH_N*CNT_W-1:0]  cmpBus;

  qpwm_ctrl #(.TOP_INIT(TOP_INIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .topAct(topAct), .strb(strb), .cnt(cnt), .loadMode(loadMode), .topCfg(topCfg),
    .periodEnd(periodEnd)
  );

  qpwm_datapath #(.TOP_INIT(TOP_INIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadMode(loadMode), .cnt(cnt),
    .topCfg(topCfg), .smpValid(smpValid), .smpWord(smpWord), .smpReady(smpReady),
    .topAct(topAct), .pwmOut(pwmOut), .cmpBus(cmpBus)
  );
endmodule

// File: rtl/quad_pwm_chk.sv
module quad_pwm_chk
  import qpwm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable,
  input logic                  periodEnd,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      topAct,
  input logic [CH_N-1:0]       pwmOut,
  input logic [CH_N*CNT_W-1:0] cmpBus
);
  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> pwmOut == '0);

  // R2
  period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd |-> cnt == '0);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> cnt <= topAct);

  // R12
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && enable && $past(enable) && !periodEnd) |-> $stable(cmpBus));
endmodule

bind quad_pwm_gen quad_pwm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .enable(strb.run), .periodEnd(periodEnd),
  .cnt(cnt), .topAct(topAct), .pwmOut(pwmOut), .cmpBus(cmpBus)
);

// File: tb/test_quad_pwm_gen.sv
`timescale 1ns/1ps
module test_quad_pwm_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        smpValid = 1'b0;
  logic [15:0] smpWord = '0;
  logic        smpReady;
  logic [3:0]  pwmOut;
  logic        periodEnd;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int measPeriod;
  int measHigh [4];

  always #2.5 clk = ~clk;

  quad_pwm_gen i_quad_pwm_gen (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .smpValid(smpValid), .smpWord(smpWord), .smpReady(smpReady),
    .pwmOut(pwmOut), .periodEnd(periodEnd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pushWord(logic [15:0] w);
    @(negedge clk); smpValid = 1'b1; smpWord = w;
    while (!smpReady) @(negedge clk);
    @(negedge clk); smpValid = 1'b0;
  endtask

  // ctrl word: enable bit0, up-down bit1, load mode bits 3:2
  function automatic logic [15:0] ctl(bit en, bit ud, int lm);
    return 16'(en) | (16'(ud) << 1) | (16'(lm) << 2);
  endfunction

  // disabled setup, step applied at once, then enabled
  task automatic setup(bit ud, int lm, int n, logic [15:0] top, logic [15:0] w [4], int nw);
    cfgWrite(2'd0, ctl(0, ud, lm));
    cfgWrite(2'd1, 16'(n));
    cfgWrite(2'd2, top);
    for (int k = 0; k < nw; k++) pushWord(w[k]);
    repeat (2) @(negedge clk);
    cfgWrite(2'd0, ctl(1, ud, lm));
  endtask

  task automatic measure();
    int guard = 0;
    @(negedge clk);
    while (!periodEnd && guard < 70000) begin @(negedge clk); guard++; end
    measPeriod = 0;
    for (int k = 0; k < 4; k++) measHigh[k] = 0;
    do begin
      for (int k = 0; k < 4; k++) measHigh[k] += int'(pwmOut[k]);
      measPeriod++;
      @(negedge clk);
    end while (!periodEnd && measPeriod < 70000);
  endtask

  function automatic int expPeriod(bit ud, int t, int n);
    int p = ud ? ((t == 0) ? 1 : 2 * t) : t + 1;
    return p << n;
  endfunction

  function automatic int expHigh(logic [15:0] w, bit ud, int t, int n);
    int c = int'(w[14:0]);
    int a;
    if (c == 0) a = 0;
    else if (c >= t) a = ud ? ((t == 0) ? 1 : 2 * t) : t + 1;
    else a = ud ? 2 * c - 1 : c;
    a = a << n;
    return w[15] ? expPeriod(ud, t, n) - a : a;
  endfunction

  task automatic tReset();
    @(negedge clk);
    check("R11 reset outputs", int'(pwmOut), 0);
    check("R2 reset periodEnd", int'(periodEnd), 0);
    check("R12 reset ready", int'(smpReady), 1);
  endtask

  task automatic tCommon();
    logic [15:0] w [4] = '{16'd4, 16'd0, 16'd0, 16'd0};
    setup(0, 0, 2, 16'd9, w, 1);
    measure();
    check("R1 R2 period N=2 T=9", measPeriod, 40);
    for (int k = 0; k < 4; k++) check("R7 common high", measHigh[k], expHigh(w[0], 0, 9, 2));
  endtask

  task automatic tEdges();
    logic [15:0] w [4] = '{16'd0, 16'h8007, 16'd25, 16'd20};
    setup(0, 2, 0, 16'd20, w, 4);
    measure();
    check("R2 period T=20", measPeriod, 21);
    check("R6 compare zero", measHigh[0], 0);
    check("R5 inverted", measHigh[1], 14);
    check("R6 above top", measHigh[2], 21);
    check("R6 equal top / R9 order", measHigh[3], 21);
  endtask

  task automatic tGrouped();
    logic [15:0] w [4] = '{16'd3, 16'h800A, 16'd0, 16'd0};
    setup(0, 1, 1, 16'd15, w, 2);
    measure();
    check("R1 period N=1", measPeriod, 32);
    check("R8 ch0", measHigh[0], 6);
    check("R8 ch1", measHigh[1], 6);
    check("R8 ch2", measHigh[2], 12);
    check("R8 ch3", measHigh[3], 12);
  endtask

  task automatic tUpDown();
    logic [15:0] w [4] = '{16'd1, 16'd4, 16'd8, 16'd0};
    setup(1, 2, 0, 16'd8, w, 4);
    measure();
    check("R3 period", measPeriod, 16);
    for (int k = 0; k < 4; k++) check("R3 R9 high", measHigh[k], expHigh(w[k], 1, 8, 0));
  endtask

  task automatic tWave();
    logic [15:0] w [4] = '{16'd2, 16'd5, 16'd6, 16'd11};
    setup(0, 3, 0, 16'd50, w, 4);
    measure();
    check("R10 period from word four", measPeriod, 12);
    check("R10 ch0", measHigh[0], 2);
    check("R10 ch1", measHigh[1], 5);
    check("R10 ch2", measHigh[2], 6);
    check("R10 ch3 low", measHigh[3], 0);
  endtask

  task automatic tClamp();
    logic [15:0] w [4] = '{16'h4000, 16'd0, 16'd0, 16'd0};
    setup(0, 0, 0, 16'hFFFF, w, 1);
    measure();
    check("R4 clamped period", measPeriod, 32768);
    check("R4 R7 high", measHigh[0], 16384);
  endtask

  task automatic tBoundary();
    logic [15:0] w [4] = '{16'd30, 16'd30, 16'd30, 16'd30};
    setup(0, 2, 0, 16'd49, w, 4);
    measure();
    check("R12 initial high", measHigh[0], 30);
    // measure() ended on the negedge where a new period began
    for (int k = 0; k < 4; k++) pushWord(16'd5);
    @(negedge clk);
    check("R12 ready low while staged", int'(smpReady), 0);
    check("R12 old compare still in use", int'(pwmOut), 15);
    measure();
    for (int k = 0; k < 4; k++) check("R12 new compare next period", measHigh[k], 5);
  endtask

  task automatic tDisable();
    int bad = 0;
    cfgWrite(2'd0, ctl(0, 0, 2));
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (pwmOut != 0) bad++; end
    check("R11 disabled low", bad, 0);
    cfgWrite(2'd0, ctl(1, 0, 2));
    measure();
    check("R11 period after re-enable", measPeriod, 50);
    for (int k = 0; k < 4; k++) check("R11 retained compare", measHigh[k], 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tCommon();
    tEdges();
    tGrouped();
    tUpDown();
    tWave();
    tClamp();
    tBoundary();
    tDisable();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule